// File: doc/BRIEF.md
# Shift-add constant scaler

The block scales an unsigned 8-bit sample by one of a small set of fixed factors. A 2-bit select picks the factor: times ten, times fourteen, about one third, or an unchanged copy of the sample. No factor uses a multiplier. Each is built from wired shifts with one or two adders or subtractors.

Times ten adds the sample shifted left by three to the sample shifted left by one. Times fourteen takes the sample shifted left by four and subtracts the sample shifted left by one. This avoids adding eight, four and two as separate terms.

The one-third factor is 85/256. A first sum `x + x/4` is formed once. That sum is then reused at two right shifts, `s/4 + s/64`. This saves an adder compared with summing the four terms 64, 16, 4 and 1 one by one. The fractional bits are carried exactly, and the result is truncated to an integer only at the output.

A sample is taken on a clock edge when its valid flag is high. The scaled result and its valid flag come out of a register one clock later. While no valid sample arrives, the result register holds its last value.

Top module: `const_scaler`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `y_o` is 0. Reset acts asynchronously.
- R2: Mode 2'b00 gives `y_o = 10*x` exactly, for every 8-bit `x`.
- R3: Mode 2'b01 gives `y_o = 14*x` exactly, for every 8-bit `x`.
- R4: Mode 2'b10 gives `y_o = floor(85*x/256)`, for every 8-bit `x`.
- R5: Mode 2'b11 gives `y_o = x`, zero-extended to 12 bits.
- R6: `valid_o` equals `valid_i` delayed by one clock. A sample taken at edge k appears on `y_o` right after edge k. No result is emitted without a sample.
- R7: At an edge where `valid_i` is low, `y_o` keeps its value, whatever `x_i` and `mode_i` are.
- R8: Samples may arrive on every clock, with a different mode each time. Each result uses only the sample and mode captured with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample present this cycle |
| mode_i | input | 2 | Factor select: 00 x10, 01 x14, 10 x85/256, 11 copy |
| x_i | input | 8 | Unsigned input sample |
| valid_o | output | 1 | Result present |
| y_o | output | 12 | Scaled result |

## Verification
Two things can fall in the same cycle: the registered result of one sample going out, and the next sample, possibly with a new mode, being captured. The bench provokes this by sweeping all 256 inputs against all four modes back to back, so the mode changes on every clock. A queue of expected values, filled by the driver, must match every result in order. Idle cycles with changing inputs then show that the held result and the low valid flag are left alone.

// File: rtl/scaler_pkg.sv
package scaler_pkg;
  typedef enum logic [1:0] {
    MODE_X10   = 2'b00,
    MODE_X14   = 2'b01,
    MODE_THIRD = 2'b10,
    MODE_PASS  = 2'b11
  } scale_mode_e;
endpackage

// File: rtl/scaler_x10.sv
module scaler_x10 #(
  parameter int DATA_W = 8,
  parameter int OUT_W  = 12
) (
  input  logic [DATA_W-1:0] x_i,
  output logic [OUT_W-1:0]  y_o
);
  // 10 = 8 + 2
  assign y_o = OUT_W'({x_i, 3'b000}) + OUT_W'({x_i, 1'b0});

  always_comb begin
    p_exact_r2: assert (int'(y_o) == int'(x_i) * 10);
  end
endmodule

// File: rtl/scaler_x14.sv
module scaler_x14 #(
  parameter int DATA_W = 8,
  parameter int OUT_W  = 12
) (
  input  logic [DATA_W-1:0] x_i,
  output logic [OUT_W-1:0]  y_o
);
  // 14 = 16 - 2, one subtractor instead of two adders
  assign y_o = OUT_W'({x_i, 4'b0000}) - OUT_W'({x_i, 1'b0});

  always_comb begin
    p_exact_r3: assert (int'(y_o) == int'(x_i) * 14);
  end
endmodule

// File: rtl/scaler_third.sv
module scaler_third #(
  parameter int DATA_W = 8,
  parameter int OUT_W  = 12
) (
  input  logic [DATA_W-1:0] x_i,
  output logic [OUT_W-1:0]  y_o
);
  // 85/256 = (1 + 1/4) * (1/4 + 1/64); total right shift 8, keep all fraction bits
  localparam int FRAC_W = 8;
  localparam int FX_W   = DATA_W + FRAC_W + 1;

  logic [FX_W-1:0] x_fx;
  logic [FX_W-1:0] s_fx;
  logic [FX_W-1:0] t_fx;

  assign x_fx = {1'b0, x_i, {FRAC_W{1'b0}}};
  assign s_fx = x_fx + (x_fx >> 2);
  assign t_fx = (s_fx >> 2) + (s_fx >> 6);
  assign y_o  = OUT_W'(t_fx >> FRAC_W);

  always_comb begin
    p_floor_r4: assert ((int'(y_o) * 256 <= int'(x_i) * 85) &&
                        (int'(x_i) * 85 - int'(y_o) * 256 < 256));
  end
endmodule

// File: rtl/const_scaler.sv
module const_scaler
  import scaler_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OUT_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] x_i,
  output logic              valid_o,
  output logic [OUT_W-1:0]  y_o
);
  localparam int N_PATH = 4;

  scale_mode_e      mode;
  logic [OUT_W-1:0] path_y [N_PATH];
  logic [OUT_W-1:0] y_next;

  assign mode = scale_mode_e'(mode_i);

  scaler_x10 #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_x10 (
    .x_i(x_i), .y_o(path_y[MODE_X10])
  );
  scaler_x14 #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_x14 (
    .x_i(x_i), .y_o(path_y[MODE_X14])
  );
  scaler_third #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_third (
    .x_i(x_i), .y_o(path_y[MODE_THIRD])
  );
  assign path_y[MODE_PASS] = OUT_W'(x_i);

  always_comb begin
    y_next = '0;
    for (int i = 0; i < N_PATH; i++) begin
      if (mode_i == i[1:0]) y_next = path_y[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      y_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) y_o <= y_next;
    end
  end

  p_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(y_o));

  p_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode == MODE_PASS) |=> (y_o == OUT_W'($past(x_i))));

  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && y_o == '0));
endmodule

// File: tb/const_scaler_test.sv
module const_scaler_test;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        valid_i;
  logic [1:0]  mode_i;
  logic [7:0]  x_i;
  logic        valid_o;
  logic [11:0] y_o;

  int    checks = 0;
  int    errors = 0;
  int    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  const_scaler uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .x_i(x_i), .valid_o(valid_o), .y_o(y_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model(input int x, input int m);
    case (m)
      0:       return x * 10;
      1:       return x * 14;
      2:       return (x * 85) >> 8;
      default: return x;
    endcase
  endfunction

  function automatic string tag_of(input int m);
    case (m)
      0:       return "R2 R8 x10";
      1:       return "R3 R8 x14";
      2:       return "R4 R8 x85/256";
      default: return "R5 R8 copy";
    endcase
  endfunction

  task automatic drive(input bit v, input int m, input int x);
    @(negedge clk);
    valid_i = v;
    mode_i  = m[1:0];
    x_i     = x[7:0];
    if (v) begin
      exp_q.push_back(model(x, m));
      tag_q.push_back(tag_of(m));
    end
  endtask

  // monitor: pop one expected item per emitted result
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_ni && valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 result without sample", 1, 0);
        end else begin
          int    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(int'(y_o) == e, t, int'(y_o), e);
        end
      end
    end
  end

  initial begin
    #1ms;
    checks++;
    errors++;
    $display("FAIL watchdog R6 actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_ni  = 1'b0;
    valid_i = 1'b0;
    mode_i  = 2'b00;
    x_i     = 8'h00;
    repeat (3) @(negedge clk);
    #2;
    check(valid_o == 1'b0, "R1 valid in reset", int'(valid_o), 0);
    check(y_o == 12'd0, "R1 y in reset", int'(y_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // full sweep, mode changes on every clock
    for (int x = 0; x < 256; x++) begin
      for (int m = 0; m < 4; m++) drive(1'b1, m, x);
    end
    drive(1'b0, 0, 0);
    drive(1'b0, 0, 0);
    #2;
    check(exp_q.size() == 0, "R8 results drained", exp_q.size(), 0);

    // latency and hold
    drive(1'b1, 0, 7);
    drive(1'b0, 1, 200);
    #2;
    check(valid_o == 1'b1, "R6 valid one clock later", int'(valid_o), 1);
    check(y_o == 12'd70, "R6 result one clock later", int'(y_o), 70);
    drive(1'b0, 3, 99);
    #2;
    check(valid_o == 1'b0, "R6 valid drops", int'(valid_o), 0);
    check(y_o == 12'd70, "R7 hold with idle copy mode", int'(y_o), 70);
    drive(1'b0, 2, 255);
    #2;
    check(y_o == 12'd70, "R7 hold with idle third mode", int'(y_o), 70);
    drive(1'b0, 1, 255);
    #2;
    check(y_o == 12'd70, "R7 hold with idle x14 mode", int'(y_o), 70);
    check(exp_q.size() == 0, "R6 no extra result", exp_q.size(), 0);

    // boundary: top of x14 range, then async reset
    drive(1'b1, 1, 255);
    drive(1'b0, 0, 0);
    #2;
    check(y_o == 12'd3570, "R3 top of range", int'(y_o), 3570);
    rst_ni = 1'b0;
    #1;
    check(y_o == 12'd0, "R1 async reset y", int'(y_o), 0);
    check(valid_o == 1'b0, "R1 async reset valid", int'(valid_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    drive(1'b1, 2, 3);
    drive(1'b0, 0, 0);
    drive(1'b0, 0, 0);
    #2;
    check(y_o == 12'd0, "R4 small input truncates", int'(y_o), 0);
    check(exp_q.size() == 0, "R6 all results seen", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule